// File: doc/BRIEF.md
# Systolic Minimum-SAD Chain

This block keeps, for every sub-block of a 16x16 macroblock, the smallest sum of absolute differences (SAD) seen over a full search, and the motion vector that produced it. A fixed number of comparator stages sit in a line. Each stage is fed by its own SAD engine, which is not part of this block. Stage k evaluates candidate positions k, k+NSTAGE, k+2·NSTAGE and so on, in raster order. There are fewer stages than positions, so every stage works through several search regions in turn.

The chain passes a running-minimum token from stage to stage, one clock apart. Stage 0 reads the current best entry for a sub-block from the result register file. Each following stage gets that token one cycle after its upstream neighbour and sets it against the SAD its own engine computed for the same sub-block at a different position. The winner moves on. The last stage writes the token back into the file. A done flag rises once the 16x16 result of the final round has been written. A one-cycle macroblock-start pulse resets the file and the flag for the next macroblock.

Top module: `msad_chain`

## Requirements
- R1: After reset, and one cycle after a `mb_start_i` pulse, every entry reads SAD 0xFFFF with both motion-vector fields 0, and `done_o` is low.
- R2: Sub-block indices are encoded as follows. Index 0 is the 16x16 block. Indices 1-2 are the 16x8 halves (top, bottom). Indices 3-4 are the 8x16 halves (left, right). Indices 5-8 are the 8x8 quarters in raster order. Indices 9-16 are the 8x4 halves, top then bottom within each quarter. Indices 17-24 are the 4x8 halves, left then right within each quarter. Indices 25-40 are the 4x4 blocks in raster order. The read port returns entry `rd_idx_i` combinationally.
- R3: Stage k takes its inputs for a sub-block exactly k cycles after stage 0 took that sub-block. Stage 0 draws the running token from the file, and stage k>0 draws it from the register of stage k-1. The input index of a stage must match the index of the token it receives.
- R4: A stage replaces the token's SAD and vector with its own only when its SAD is strictly smaller. On a tie the held candidate stays, so the earlier raster position wins.
- R5: After a full search over NPOS positions, each entry holds the minimum SAD over all positions, together with the vector of the first position that reached it.
- R6: `done_o` rises in the cycle after the write-back of the ROUNDS-th 16x16 token (ROUNDS = NPOS/NSTAGE) and stays high until the next `mb_start_i`.
- R7: A stage k>0 whose SAD-valid input is high while no token arrives has no effect on any entry.
- R8: Motion vectors are signed 5-bit fields, horizontal and vertical. They are stored and returned exactly as presented alongside the winning SAD.
- R9: A token that entered stage 0 in cycle c is written at the edge that ends cycle c+NSTAGE and can be read in cycle c+NSTAGE+1. The same sub-block must not re-enter stage 0 earlier than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mb_start_i | input | 1 | Start of a macroblock: clears the file and the done flag |
| sad_vld_i | input | NSTAGE | SAD-valid strobe, one per stage |
| sad_idx_i | input | NSTAGE x 6 | Sub-block index, one per stage |
| sad_i | input | NSTAGE x 16 | Candidate SAD, one per stage |
| mvx_i | input | NSTAGE x 5 | Candidate horizontal vector, signed |
| mvy_i | input | NSTAGE x 5 | Candidate vertical vector, signed |
| rd_idx_i | input | 6 | Result-file read index |
| rd_sad_o | output | 16 | Best SAD of entry `rd_idx_i` |
| rd_mvx_o | output | 5 | Horizontal vector of that entry |
| rd_mvy_o | output | 5 | Vertical vector of that entry |
| done_o | output | 1 | Search for the current macroblock complete |

## Verification
The bench replays complete searches over four kinds of frames: random full-range pixels, two-level pixels that create many ties, flat frames where every SAD is zero, and a saturating pattern whose 16x16 SAD is near the 16-bit limit. All 41 entries are compared with an exhaustive raster search. A design that let equal SADs replace the held candidate would report a later vector on the tie-heavy frames. A design with an off-by-one in the stage skew would mix sub-blocks and return the wrong minima. Write-back latency and the done edge are sampled on the exact cycles where they change, so a missing or extra pipeline register shows up at once. A lone valid pulse on a downstream stage probes whether tokenless inputs leak into the file.

// File: rtl/msad_pkg.sv
`timescale 1ns/1ps
package msad_pkg;
  localparam int SAD_W = 16;
  localparam int MV_W  = 5;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic [SAD_W-1:0] sad;
    logic [MV_W-1:0]  mvx;
    logic [MV_W-1:0]  mvy;
  } ent_t;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
    ent_t             ent;
  } tok_t;

  // Value an entry takes at reset and at each macroblock start.
  function automatic ent_t ent_init();
    ent_t e;
    e.sad = '1;
    e.mvx = '0;
    e.mvy = '0;
    return e;
  endfunction

  // Strict comparison: a tie never displaces the held candidate.
  function automatic logic cand_wins(logic [SAD_W-1:0] cand, logic [SAD_W-1:0] held);
    return cand < held;
  endfunction
endpackage

// File: rtl/msad_stage.sv
`timescale 1ns/1ps
module msad_stage
  import msad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tok_t             tok_i,
  input  logic             own_vld_i,
  input  logic [IDX_W-1:0] own_idx_i,
  input  ent_t             own_i,
  output tok_t             tok_o
);
  logic take;    // own candidate beats the token
  logic orphan;  // own strobe with no token to compare against
  logic tie;     // equal SADs, held candidate kept

  assign take   = own_vld_i && tok_i.vld && cand_wins(own_i.sad, tok_i.ent.sad);
  assign orphan = own_vld_i && !tok_i.vld;
  assign tie    = own_vld_i && tok_i.vld && (own_i.sad == tok_i.ent.sad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_o <= '0;
    end else begin
      tok_o.vld <= tok_i.vld;
      tok_o.idx <= tok_i.idx;
      tok_o.ent <= take ? own_i : tok_i.ent;
    end
  end

  a_r4_never_worse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_i.vld |=> tok_o.ent.sad <= $past(tok_i.ent.sad));
  a_r4_tie_keeps_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie |=> tok_o.ent == $past(tok_i.ent));
  a_r3_idx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_i.vld |=> (tok_o.vld && tok_o.idx == $past(tok_i.idx)));
  a_r7_orphan_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orphan |=> !tok_o.vld);
  a_r3_lanes_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_vld_i && tok_i.vld) |-> own_idx_i == tok_i.idx);
endmodule

// File: rtl/msad_file.sv
`timescale 1ns/1ps
module msad_file
  import msad_pkg::*;
#(
  parameter int NSUB = 41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  tok_t             wr_i,
  input  logic [IDX_W-1:0] ra_idx_i,
  output ent_t             ra_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output ent_t             rb_o
);
  ent_t mem [NSUB];
  logic wr_hit;

  assign wr_hit = wr_i.vld && (wr_i.idx < IDX_W'(NSUB));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSUB; i++) mem[i] <= ent_init();
    end else if (clr_i) begin
      for (int i = 0; i < NSUB; i++) mem[i] <= ent_init();
    end else if (wr_hit) begin
      mem[wr_i.idx] <= wr_i.ent;
    end
  end

  always_comb begin
    ra_o = (ra_idx_i < IDX_W'(NSUB)) ? mem[ra_idx_i] : ent_init();
    rb_o = (rb_idx_i < IDX_W'(NSUB)) ? mem[rb_idx_i] : ent_init();
  end

  // R5: a write-back never raises a stored minimum.
  a_r5_file_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !clr_i) |-> wr_i.ent.sad <= mem[wr_i.idx].sad);
endmodule

// File: rtl/msad_done.sv
`timescale 1ns/1ps
module msad_done
  import msad_pkg::*;
#(
  parameter int ROUNDS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  tok_t wr_i,
  output logic done_o
);
  localparam int CW = $clog2(ROUNDS + 1);

  logic [CW-1:0] cnt;
  logic          big_wr;  // 16x16 token leaving the final stage

  assign big_wr = wr_i.vld && (wr_i.idx == '0);
  assign done_o = (cnt == CW'(ROUNDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (clr_i)            cnt <= '0;
    else if (big_wr && !done_o) cnt <= cnt + 1'b1;
  end

  a_r6_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);
  a_r1_clear_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o);
  a_r6_done_on_big_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(big_wr));
endmodule

// File: rtl/msad_chain.sv
`timescale 1ns/1ps
module msad_chain
  import msad_pkg::*;
#(
  parameter int NSTAGE = 4,
  parameter int NSUB   = 41,
  parameter int NPOS   = 256
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         mb_start_i,
  input  logic [NSTAGE-1:0]            sad_vld_i,
  input  logic [NSTAGE-1:0][IDX_W-1:0] sad_idx_i,
  input  logic [NSTAGE-1:0][SAD_W-1:0] sad_i,
  input  logic [NSTAGE-1:0][MV_W-1:0]  mvx_i,
  input  logic [NSTAGE-1:0][MV_W-1:0]  mvy_i,
  input  logic [IDX_W-1:0]             rd_idx_i,
  output logic [SAD_W-1:0]             rd_sad_o,
  output logic [MV_W-1:0]              rd_mvx_o,
  output logic [MV_W-1:0]              rd_mvy_o,
  output logic                         done_o
);
  localparam int ROUNDS = NPOS / NSTAGE;

  tok_t tok_in  [NSTAGE];
  tok_t tok_out [NSTAGE];
  ent_t own     [NSTAGE];
  ent_t head;     // entry read for stage 0
  ent_t rd_ent;
  tok_t wb;       // write-back token from the final stage

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    assign own[k].sad = sad_i[k];
    assign own[k].mvx = mvx_i[k];
    assign own[k].mvy = mvy_i[k];

    if (k == 0) begin : g_head
      assign tok_in[k].vld = sad_vld_i[k];
      assign tok_in[k].idx = sad_idx_i[k];
      assign tok_in[k].ent = head;
    end else begin : g_link
      assign tok_in[k] = tok_out[k-1];
    end

    msad_stage u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tok_i     (tok_in[k]),
      .own_vld_i (sad_vld_i[k]),
      .own_idx_i (sad_idx_i[k]),
      .own_i     (own[k]),
      .tok_o     (tok_out[k])
    );
  end

  assign wb = tok_out[NSTAGE-1];

  msad_file #(.NSUB(NSUB)) u_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mb_start_i),
    .wr_i     (wb),
    .ra_idx_i (sad_idx_i[0]),
    .ra_o     (head),
    .rb_idx_i (rd_idx_i),
    .rb_o     (rd_ent)
  );

  msad_done #(.ROUNDS(ROUNDS)) u_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mb_start_i),
    .wr_i   (wb),
    .done_o (done_o)
  );

  assign rd_sad_o = rd_ent.sad;
  assign rd_mvx_o = rd_ent.mvx;
  assign rd_mvy_o = rd_ent.mvy;
endmodule

// File: tb/sim_msad_chain.sv
`timescale 1ns/1ps
module sim_msad_chain;
  localparam int NS = 4, NB = 41, NP = 256;
  localparam int ROUNDS = NP / NS, TOTAL = ROUNDS * NB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, mb_start, done;
  logic [NS-1:0]   vld;
  logic [NS-1:0][5:0]  idx;
  logic [NS-1:0][15:0] sad;
  logic [NS-1:0][4:0]  mvx, mvy;
  logic [5:0]  rd_idx;
  logic [15:0] rd_sad;
  logic [4:0]  rd_mvx, rd_mvy;

  msad_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .mb_start_i(mb_start),
    .sad_vld_i(vld), .sad_idx_i(idx), .sad_i(sad), .mvx_i(mvx), .mvy_i(mvy),
    .rd_idx_i(rd_idx), .rd_sad_o(rd_sad), .rd_mvx_o(rd_mvx), .rd_mvy_o(rd_mvy),
    .done_o(done)
  );

  int cur [16][16];
  int refw [31][31];
  int prim [NP][16];
  int stab [NP][NB];
  int e_sad [NB], e_x [NB], e_y [NB];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2 geometry, in 4x4-block units
  task automatic rect(int b, output int x0, output int y0, output int w, output int h);
    int q, hf;
    if (b == 0) begin x0 = 0; y0 = 0; w = 4; h = 4; end
    else if (b <= 2) begin x0 = 0; y0 = (b-1)*2; w = 4; h = 2; end
    else if (b <= 4) begin x0 = (b-3)*2; y0 = 0; w = 2; h = 4; end
    else if (b <= 8) begin q = b-5; x0 = (q%2)*2; y0 = (q/2)*2; w = 2; h = 2; end
    else if (b <= 16) begin q = (b-9)/2; hf = (b-9)%2; x0 = (q%2)*2; y0 = (q/2)*2+hf; w = 2; h = 1; end
    else if (b <= 24) begin q = (b-17)/2; hf = (b-17)%2; x0 = (q%2)*2+hf; y0 = (q/2)*2; w = 1; h = 2; end
    else begin q = b-25; x0 = q%4; y0 = q/4; w = 1; h = 1; end
  endtask

  task automatic build(int mode);
    int x0, y0, w, h, s, vx, vy;
    for (int y = 0; y < 16; y++) for (int x = 0; x < 16; x++)
      case (mode)
        0: cur[y][x] = int'($urandom_range(255, 0));
        1: cur[y][x] = int'($urandom_range(1, 0));
        2: cur[y][x] = 7;
        default: cur[y][x] = 255;
      endcase
    for (int y = 0; y < 31; y++) for (int x = 0; x < 31; x++)
      case (mode)
        0: refw[y][x] = int'($urandom_range(255, 0));
        1: refw[y][x] = int'($urandom_range(1, 0));
        2: refw[y][x] = 7;
        default: refw[y][x] = 0;
      endcase
    for (int p = 0; p < NP; p++) begin
      vx = p % 16; vy = p / 16;
      for (int j = 0; j < 16; j++) begin
        s = 0;
        for (int y = 0; y < 4; y++) for (int x = 0; x < 4; x++) begin
          int d;
          d = cur[4*(j/4)+y][4*(j%4)+x] - refw[vy+4*(j/4)+y][vx+4*(j%4)+x];
          s += (d < 0) ? -d : d;
        end
        prim[p][j] = s;
      end
      for (int b = 0; b < NB; b++) begin
        rect(b, x0, y0, w, h);
        s = 0;
        for (int yy = 0; yy < h; yy++) for (int xx = 0; xx < w; xx++)
          s += prim[p][(y0+yy)*4 + x0+xx];
        stab[p][b] = s;
      end
    end
    // exhaustive raster search, strict less-than (R4, R5)
    for (int b = 0; b < NB; b++) begin
      e_sad[b] = 65535; e_x[b] = 0; e_y[b] = 0;
      for (int p = 0; p < NP; p++)
        if (stab[p][b] < e_sad[b]) begin
          e_sad[b] = stab[p][b]; e_x[b] = p % 16 - 8; e_y[b] = p / 16 - 8;
        end
    end
  endtask

  task automatic check_clear(string req);
    for (int b = 0; b < NB; b++) begin
      rd_idx = 6'(b); #1;
      chk(req, "cleared sad", int'(rd_sad), 65535);
      chk(req, "cleared mv", int'(rd_mvx) + int'(rd_mvy), 0);
    end
    chk(req, "done low", int'(done), 0);
  endtask

  task automatic run_mb(int mode);
    int r0_sad, r0_x, r0_y, slast, s, p;
    build(mode);
    @(negedge clk); mb_start = 1'b1;
    @(negedge clk); mb_start = 1'b0;
    check_clear("R1");
    rd_idx = 6'd0;
    r0_sad = 65535; r0_x = 0; r0_y = 0;
    for (int k = 0; k < NS; k++)
      if (stab[k][0] < r0_sad) begin r0_sad = stab[k][0]; r0_x = k % 16 - 8; r0_y = k / 16 - 8; end
    slast = (ROUNDS - 1) * NB;
    for (int t = 0; t < TOTAL + NS + 2; t++) begin
      @(negedge clk);
      for (int k = 0; k < NS; k++) begin
        s = t - k;
        if (s >= 0 && s < TOTAL) begin
          p = NS * (s / NB) + k;   // R3 skew: stage k sees step s at cycle s+k
          vld[k] = 1'b1; idx[k] = 6'(s % NB); sad[k] = 16'(stab[p][s % NB]);
          mvx[k] = 5'(p % 16 - 8); mvy[k] = 5'(p / 16 - 8);
        end else begin
          vld[k] = 1'b0; idx[k] = '0; sad[k] = '0; mvx[k] = '0; mvy[k] = '0;
        end
      end
      if (t == NS) chk("R9", "entry0 before write-back", int'(rd_sad), 65535);
      if (t == NS + 1) begin
        chk("R9", "entry0 after round0", int'(rd_sad), r0_sad);
        chk("R9", "entry0 mvx after round0", int'($signed(rd_mvx)), r0_x);
        chk("R9", "entry0 mvy after round0", int'($signed(rd_mvy)), r0_y);
      end
      if (t == slast + NS) chk("R6", "done before last write", int'(done), 0);
      if (t == slast + NS + 1) chk("R6", "done after last write", int'(done), 1);
    end
    @(negedge clk);
    chk("R6", "done held", int'(done), 1);
    for (int b = 0; b < NB; b++) begin
      rd_idx = 6'(b); #1;
      chk("R5", $sformatf("mode%0d sad[%0d]", mode, b), int'(rd_sad), e_sad[b]);
      chk("R8", $sformatf("mode%0d mvx[%0d]", mode, b), int'($signed(rd_mvx)), e_x[b]);
      chk("R4", $sformatf("mode%0d mvy[%0d]", mode, b), int'($signed(rd_mvy)), e_y[b]);
    end
  endtask

  initial begin
    rst_n = 1'b0; mb_start = 1'b0; vld = '0; idx = '0; sad = '0; mvx = '0; mvy = '0; rd_idx = '0;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_clear("R1");
    run_mb(0);
    // R7: lone strobe on stage 2, no token travelling
    @(negedge clk);
    vld[2] = 1'b1; idx[2] = 6'd5; sad[2] = '0; mvx[2] = 5'd3; mvy[2] = 5'd3;
    @(negedge clk);
    vld[2] = 1'b0;
    repeat (NS + 2) @(negedge clk);
    rd_idx = 6'd5; #1;
    chk("R7", "entry5 sad untouched", int'(rd_sad), e_sad[5]);
    chk("R7", "entry5 mvx untouched", int'($signed(rd_mvx)), e_x[5]);
    chk("R7", "done untouched", int'(done), 1);
    run_mb(1);
    run_mb(2);
    run_mb(3);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule